// File: doc/BRIEF.md
# Dual-Master Bus Arbiter

This block decides which of two upstream masters may drive a single shared downstream bus. Each master has a request strobe, a release strobe and a grant/connect-enable output that closes its side of the bus switch. The two interfaces are identical, so software is the same on both sides. When the bus is free and both masters ask in the same cycle, exactly one winner is chosen. A request made while the other master holds the bus is queued and served later.

The owner is protected for a programmable reserve window. The window is counted in prescaler ticks of `TICK_DIV` clock cycles. Once the window has run out, a queued request from the other master takes the bus over, and the owner receives a one-cycle lost event. A reserve value of zero means the owner keeps the bus until it releases it. An optional idle watchdog watches a downstream activity strobe. After `IDLE_TICKS` ticks without activity it disconnects both masters.

Every handover passes through a cycle in which neither connect-enable is high. The new owner receives a one-cycle granted event. An active-low asynchronous reset and a synchronous software reset both restore the power-up state.

Top module: `dual_bus_arbiter`

## Requirements
- R1: After `rst_n` low, or after `soft_rst` high on a clock edge, both connect-enables and all four event outputs are 0. All queued requests are dropped and the tie preference returns to master 0.
- R2: A single request strobe seen at an edge while the bus is free raises that master's connect-enable and its granted pulse in the following cycle. The granted pulse lasts exactly one cycle.
- R3: When both masters' requests (strobed in the same cycle or already queued) meet on a free bus, the first such tie after reset goes to master 0 and later ties alternate. The loser stays queued.
- R4: At most one connect-enable is high in any cycle. A connect-enable never rises in the cycle right after the other one was high.
- R5: When the owner strobes release, its connect-enable falls in the next cycle with no lost pulse. If the other master is queued, that master is granted one cycle later.
- R6: With reserve value `r` > 0 and the other master queued, the owner's connect-enable stays high for exactly `r*TICK_DIV+1` cycles from its grant. It then falls together with a one-cycle lost pulse, and the queued master is granted one cycle later.
- R7: With reserve value 0, a queued request never preempts the owner. It is served only after an explicit release.
- R8: After the reserve window has expired with nothing queued, the owner keeps the bus. A later request from the other master drops the owner in the next cycle, with a lost pulse, and grants the requester one cycle after that.
- R9: With `idle_en` high, if the owner sees no `bus_act` for `IDLE_TICKS*TICK_DIV` cycles, it is disconnected with a lost pulse, and its connect-enable has then been high for that count plus one cycle. The timeout also drops any queued request. A `bus_act` strobe restarts the count.
- R10: A release strobe from a non-owner cancels its queued request. A request strobe from the current owner has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous software reset |
| req0 | input | 1 | Master 0 request strobe |
| rel0 | input | 1 | Master 0 release strobe |
| req1 | input | 1 | Master 1 request strobe |
| rel1 | input | 1 | Master 1 release strobe |
| reserve | input | RES_W | Reserve window in ticks, 0 = no window |
| idle_en | input | 1 | Enables the idle watchdog |
| bus_act | input | 1 | Downstream activity strobe |
| conn0 | output | 1 | Grant / switch enable for master 0 |
| conn1 | output | 1 | Grant / switch enable for master 1 |
| granted0 | output | 1 | One-cycle grant event to master 0 |
| granted1 | output | 1 | One-cycle grant event to master 1 |
| lost0 | output | 1 | One-cycle lost event to master 0 |
| lost1 | output | 1 | One-cycle lost event to master 1 |

## Verification
The bound checker watches four rules on every cycle:
- the two connect-enables are never high together, and neither rises the cycle after the other was high;
- a granted pulse coincides exactly with a rising connect-enable;
- a lost pulse coincides only with a connect-enable that just fell;
- both events last a single cycle.

The cycle count of the reserve window, the idle timeout, the alternating tie winner, the cancelling of queued requests and the reset of queue state can only be shown by the bench's directed scenarios. Those scenarios count cycles at the ports.

// File: rtl/dual_bus_arbiter.sv
module dual_bus_arbiter #(
  parameter int TICK_DIV   = 4,
  parameter int RES_W      = 8,
  parameter int IDLE_TICKS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             req0,
  input  logic             rel0,
  input  logic             req1,
  input  logic             rel1,
  input  logic [RES_W-1:0] reserve,
  input  logic             idle_en,
  input  logic             bus_act,
  output logic             conn0,
  output logic             conn1,
  output logic             granted0,
  output logic             granted1,
  output logic             lost0,
  output logic             lost1
);
  localparam int PW       = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int RCW      = RES_W + PW + 1;
  localparam int IDLE_LIM = IDLE_TICKS * TICK_DIV;
  localparam int ICW      = $clog2(IDLE_LIM + 1) + 1;

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_OWN} st_t;

  st_t            st, st_n;
  logic           owner, owner_n, pref, pref_n;
  logic [1:0]     pend, pend_n, gr_n, lo_n, gr_q, lo_q;
  logic [RCW-1:0] rcnt;
  logic [ICW-1:0] icnt;

  wire [1:0]     req     = {req1, req0};
  wire [1:0]     rel     = {rel1, rel0};
  wire [1:0]     want    = (pend | req) & ~rel;
  wire [RCW-1:0] res_lim = RCW'(reserve) * RCW'(TICK_DIV);
  wire           expired = (reserve != '0) && (rcnt >= res_lim);
  wire           timeout = idle_en && (icnt >= ICW'(IDLE_LIM));
  wire           stay    = (st == S_OWN) && (st_n == S_OWN);

  always_comb begin
    st_n    = st;
    owner_n = owner;
    pref_n  = pref;
    pend_n  = want;
    gr_n    = 2'b00;
    lo_n    = 2'b00;
    case (st)
      S_IDLE: begin
        if (want == 2'b11) begin
          owner_n      = pref;
          pref_n       = ~pref;
          st_n         = S_OWN;
          gr_n[pref]   = 1'b1;
          pend_n[pref] = 1'b0;
        end else if (want != 2'b00) begin
          owner_n         = want[1];
          st_n            = S_OWN;
          gr_n[want[1]]   = 1'b1;
          pend_n[want[1]] = 1'b0;
        end
      end
      S_OWN: begin
        pend_n[owner] = 1'b0;
        if (timeout) begin
          st_n        = S_IDLE;
          lo_n[owner] = 1'b1;
          pend_n      = 2'b00;
        end else if (rel[owner]) begin
          if (want[~owner]) begin
            st_n    = S_GAP;
            owner_n = ~owner;
          end else begin
            st_n = S_IDLE;
          end
        end else if (expired && want[~owner]) begin
          st_n        = S_GAP;
          owner_n     = ~owner;
          lo_n[owner] = 1'b1;
        end
      end
      S_GAP: begin
        if (!want[owner]) begin
          st_n = S_IDLE;
        end else begin
          st_n          = S_OWN;
          gr_n[owner]   = 1'b1;
          pend_n[owner] = 1'b0;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      owner <= 1'b0;
      pref  <= 1'b0;
      pend  <= 2'b00;
      gr_q  <= 2'b00;
      lo_q  <= 2'b00;
      rcnt  <= '0;
      icnt  <= '0;
    end else if (soft_rst) begin
      st    <= S_IDLE;
      owner <= 1'b0;
      pref  <= 1'b0;
      pend  <= 2'b00;
      gr_q  <= 2'b00;
      lo_q  <= 2'b00;
      rcnt  <= '0;
      icnt  <= '0;
    end else begin
      st    <= st_n;
      owner <= owner_n;
      pref  <= pref_n;
      pend  <= pend_n;
      gr_q  <= gr_n;
      lo_q  <= lo_n;
      rcnt  <= !stay ? '0 : (rcnt == '1) ? rcnt : rcnt + 1'b1;
      icnt  <= (!stay || bus_act) ? '0 : (icnt == '1) ? icnt : icnt + 1'b1;
    end
  end

  assign conn0    = (st == S_OWN) && !owner;
  assign conn1    = (st == S_OWN) && owner;
  assign granted0 = gr_q[0];
  assign granted1 = gr_q[1];
  assign lost0    = lo_q[0];
  assign lost1    = lo_q[1];
endmodule

// File: rtl/dual_bus_arbiter_chk.sv
module dual_bus_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic conn0,
  input logic conn1,
  input logic granted0,
  input logic granted1,
  input logic lost0,
  input logic lost1
);
  // R4
  excl_conn_chk: assert property (@(posedge clk) disable iff (!rst_n) !(conn0 && conn1));
  // R4
  gap_after0_chk: assert property (@(posedge clk) disable iff (!rst_n) conn0 |=> !conn1);
  // R4
  gap_after1_chk: assert property (@(posedge clk) disable iff (!rst_n) conn1 |=> !conn0);
  // R2
  grant_edge0_chk: assert property (@(posedge clk) disable iff (!rst_n) granted0 == $rose(conn0));
  // R2
  grant_edge1_chk: assert property (@(posedge clk) disable iff (!rst_n) granted1 == $rose(conn1));
  // R2
  grant_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) (granted0 || granted1) |=> !(granted0 || granted1));
  // R6
  lost_drop0_chk: assert property (@(posedge clk) disable iff (!rst_n) lost0 |-> $fell(conn0));
  // R6
  lost_drop1_chk: assert property (@(posedge clk) disable iff (!rst_n) lost1 |-> $fell(conn1));
  // R9
  lost_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) (lost0 || lost1) |=> !(lost0 || lost1));
endmodule

bind dual_bus_arbiter dual_bus_arbiter_chk i_chk (
  .clk(clk), .rst_n(rst_n), .conn0(conn0), .conn1(conn1),
  .granted0(granted0), .granted1(granted1), .lost0(lost0), .lost1(lost1)
);

// File: tb/test_dual_bus_arbiter.sv
module test_dual_bus_arbiter;
  localparam int PERIOD     = 10;
  localparam int TICK_DIV   = 4;
  localparam int RES_W      = 8;
  localparam int IDLE_TICKS = 8;

  logic clk = 0, rst_n = 0, soft_rst = 0;
  logic req0 = 0, rel0 = 0, req1 = 0, rel1 = 0, idle_en = 0, bus_act = 0;
  logic [RES_W-1:0] reserve = '0;
  logic conn0, conn1, granted0, granted1, lost0, lost1;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  dual_bus_arbiter #(.TICK_DIV(TICK_DIV), .RES_W(RES_W), .IDLE_TICKS(IDLE_TICKS)) i_dual_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .req0(req0), .rel0(rel0), .req1(req1), .rel1(rel1),
    .reserve(reserve), .idle_en(idle_en), .bus_act(bus_act), .conn0(conn0), .conn1(conn1),
    .granted0(granted0), .granted1(granted1), .lost0(lost0), .lost1(lost1));

  function automatic int res_hold(int r);
    return r * TICK_DIV + 1;
  endfunction

  function automatic int idle_hold();
    return IDLE_TICKS * TICK_DIV + 1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_req(int m);
    if (m == 0) req0 = 1; else req1 = 1;
    step();
    req0 = 0; req1 = 0;
  endtask

  task automatic pulse_rel(int m);
    if (m == 0) rel0 = 1; else rel1 = 1;
    step();
    rel0 = 0; rel1 = 0;
  endtask

  task automatic tie();
    req0 = 1; req1 = 1;
    step();
    req0 = 0; req1 = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    bit p0, p1;
    void'($urandom(32'd1234));
    repeat (3) step();
    // R1 reset state
    chk("R1 conn after reset", {conn1, conn0}, 0);
    chk("R1 events after reset", {granted1, granted0, lost1, lost0}, 0);
    rst_n = 1;
    step();

    // R2 single request
    pulse_req(0);
    chk("R2 conn0 granted", conn0, 1);
    chk("R2 granted0 pulse", granted0, 1);
    step();
    chk("R2 granted0 one cycle", granted0, 0);
    pulse_rel(0);
    chk("R5 release drops", conn0, 0);
    chk("R5 no lost on release", lost0, 0);

    // R3 ties alternate; R5 queued loser served after release
    tie();
    chk("R3 first tie to m0", {conn1, conn0}, 1);
    pulse_rel(0);
    chk("R4 gap after release", {conn1, conn0}, 0);
    step();
    chk("R5 queued m1 granted", {granted1, conn1}, 3);
    pulse_rel(1);
    tie();
    chk("R3 second tie to m1", {conn1, conn0}, 2);
    pulse_rel(1);
    step();
    chk("R3 loser m0 served", conn0, 1);
    pulse_rel(0);

    // R6 reserve window with queued request
    reserve = 2;
    pulse_req(0);
    n = conn0 ? 1 : 0;
    pulse_req(1);
    while (conn0 && n < 200) begin n++; step(); end
    chk("R6 reserve hold cycles", n, res_hold(2));
    chk("R6 lost0 pulse", lost0, 1);
    chk("R4 gap on preempt", conn1, 0);
    step();
    chk("R6 m1 granted after gap", {granted1, conn1}, 3);
    chk("R6 lost0 one cycle", lost0, 0);

    // R8 expired window, nothing queued
    repeat (12) step();
    chk("R8 owner keeps bus", conn1, 1);
    pulse_req(0);
    chk("R8 preempt drop", {lost1, conn1}, 2);
    step();
    chk("R8 requester granted", {granted0, conn0}, 3);
    pulse_rel(0);

    // R7 reserve zero
    reserve = 0;
    pulse_req(0);
    pulse_req(1);
    repeat (40) step();
    chk("R7 no preempt", {conn1, conn0}, 1);
    pulse_rel(0);
    step();
    chk("R7 served on release", conn1, 1);
    pulse_rel(1);

    // R10 cancel and owner request ignored
    pulse_req(0);
    pulse_req(1);
    pulse_rel(1);
    pulse_req(0);
    chk("R10 owner req ignored", {granted0, conn0}, 1);
    pulse_rel(0);
    n = 0;
    repeat (4) begin step(); n += conn1; end
    chk("R10 cancelled request", n, 0);

    // R9 idle watchdog
    idle_en = 1;
    pulse_req(0);
    repeat (4) begin
      repeat (20) step();
      bus_act = 1; step(); bus_act = 0;
    end
    chk("R9 activity keeps bus", conn0, 1);
    n = 1;
    pulse_req(1);
    while (conn0 && n < 200) begin n++; step(); end
    chk("R9 idle hold cycles", n, idle_hold());
    chk("R9 lost0 on timeout", lost0, 1);
    n = 0;
    repeat (5) begin step(); n += conn1 + conn0; end
    chk("R9 queue dropped", n, 0);
    idle_en = 0;

    // R1 soft reset clears queue and tie preference
    tie();
    chk("R3 third tie to m0", conn0, 1);
    pulse_rel(0);
    step();
    chk("R3 m1 served", conn1, 1);
    pulse_req(0);
    soft_rst = 1; step(); soft_rst = 0;
    chk("R1 soft reset drops", {conn1, conn0}, 0);
    n = 0;
    repeat (4) begin step(); n += conn0 + conn1; end
    chk("R1 soft reset clears queue", n, 0);
    tie();
    chk("R1 tie pref reset", conn0, 1);
    pulse_rel(0);
    step();
    pulse_rel(1);

    // R4 R2 random traffic
    p0 = conn0; p1 = conn1;
    for (int i = 0; i < 3000; i++) begin
      req0 = ($urandom % 8) == 0;
      req1 = ($urandom % 8) == 0;
      rel0 = ($urandom % 16) == 0;
      rel1 = ($urandom % 16) == 0;
      bus_act = $urandom % 2;
      if (i % 200 == 0) reserve = RES_W'($urandom % 4);
      step();
      req0 = 0; req1 = 0; rel0 = 0; rel1 = 0;
      chk("R4 exclusive", conn0 & conn1, 0);
      chk("R4 gap", (p0 & conn1) | (p1 & conn0), 0);
      chk("R2 grant edge", {granted1, granted0}, {conn1 & ~p1, conn0 & ~p0});
      if (lost0 || lost1)
        chk("R6 lost on drop", {lost1 & p1 & ~conn1, lost0 & p0 & ~conn0}, {lost1, lost0});
      p0 = conn0; p1 = conn1;
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule